// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is a synthesizable master for the two-wire PHY management bus. It generates the management clock (MDC) from the system clock and drives or samples the bidirectional data line, which is presented as three separate signals: an output value, an output enable and an input. A host issues one command per start strobe. The command carries a read/write select, a select for the extended (Clause 45) addressing scheme, a 5-bit PHY address, a 21-bit register address and 16 bits of write data. The master sets `busy` while the frame runs. It returns 16-bit read data and an error flag.

A Clause 22 command produces one frame. A Clause 45 command produces two frames: an address frame that carries the 16-bit register number to the device selected by address bits 20:16, followed by the read or write frame to the same device. Every frame starts with a 32-bit all-ones preamble and ends with one released bit time. On reads the master samples a single turnaround bit, which the PHY must pull to 0. If that bit reads 1, the master clocks 32 more bit times without using them, returns all ones and raises the error flag.

The controller is one state machine. Its states are IDLE, PREAMBLE, HEADER, WR_TA, WR_DATA, RD_TA, RD_DATA, FLUSH and TAIL.
- IDLE goes to PREAMBLE on a start strobe.
- PREAMBLE goes to HEADER after its last bit.
- HEADER goes to WR_TA for write and address frames, and to RD_TA for read frames.
- WR_TA goes to WR_DATA.
- RD_TA goes to RD_DATA when the turnaround bit reads 0, and to FLUSH when it reads 1.
- WR_DATA, RD_DATA and FLUSH each go to TAIL after their last bit.
- TAIL goes back to PREAMBLE when a Clause 45 address frame has just finished, and to IDLE otherwise.

All state changes happen at the end of a bit time, that is, at a falling MDC edge.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with exactly 32 consecutive driven bit times of 1.
- R2: The start field is 01 for Clause 22 frames and 00 for Clause 45 frames. The opcodes are: Clause 22 read 10, Clause 22 write 01, Clause 45 address 00, Clause 45 read 11, Clause 45 write 01.
- R3: After the opcode, the master sends the 5-bit PHY address and then the 5-bit register address (Clause 22: `reg_addr[4:0]`), each MSB first. The header is therefore {start[1:0], op[1:0], phy[4:0], reg/dev[4:0]}.
- R4: On write frames and address frames, the master drives turnaround as 1 then 0 and then sends 16 data bits MSB first.
- R5: On read frames, the master releases the line after the header and samples one turnaround bit. It then shifts in 16 bits MSB first, each sampled at the falling MDC edge. These bits become `rdata` when `err`=0. The master never drives while the PHY is driving.
- R6: A read turnaround bit of 1 causes 32 further released bit times, `rdata`=0xFFFF and `err`=1.
- R7: A Clause 45 command sends an address frame with device address `reg_addr[20:16]` and data `reg_addr[15:0]`, then a read or write frame to the same device address.
- R8: Each frame ends with one released bit time. `busy` stays high for exactly 2·HALF_CYC system clocks per bit time. That is 65 bit times for a write frame, 64 for a good read frame and 80 for a failed read frame.
- R9: MDC idles low. Each high phase lasts exactly HALF_CYC clocks and each low phase at least HALF_CYC clocks. Driven data changes only while MDC is low.
- R10: `busy` rises in the clock cycle after an accepted start strobe. A start strobe that arrives while `busy` is high is ignored.
- R11: `rdata` and `err` hold their values until the next command is accepted. `err` clears when a command is accepted.
- R12: After reset, `busy`, `mdc`, `mdo_oe`, `err` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| wr | input | 1 | 1 = write, 0 = read |
| c45 | input | 1 | 1 = Clause 45 two-frame access |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 21 | Bits 20:16 = device, 15:0 = register (Clause 22 uses 4:0) |
| wdata | input | 16 | Write data |
| busy | output | 1 | Command in progress |
| rdata | output | 16 | Read result |
| err | output | 1 | Read turnaround failed |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data line output value |
| mdo_oe | output | 1 | Data line output enable |
| mdi | input | 1 | Data line input |

## Verification
The main function is driven with one table of commands. The table holds Clause 22 writes and reads at the all-ones and all-zero address extremes, and Clause 45 writes and reads. It also holds reads to a PHY that stays silent, so that the turnaround check fails. A responder on the bench decodes each frame and replies to reads. Comparing the decoded headers shows whether the start and opcode fields and the field order are right for each kind of frame. Alternating data patterns such as 8001 and 7FFE show a swapped or shifted bit. The silent-PHY cases separate the flush path from the normal read path by the exact `busy` length, and the two-frame commands show that the address frame and the data frame share one device address.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_WR_TA,
        S_WR_DATA,
        S_RD_TA,
        S_RD_DATA,
        S_FLUSH,
        S_TAIL
    } mdio_state_e;

    typedef enum logic [2:0] {
        K_C22_RD,
        K_C22_WR,
        K_C45_ADR,
        K_C45_RD,
        K_C45_WR
    } frame_kind_e;

    localparam logic [1:0] ST_C22 = 2'b01;
    localparam logic [1:0] ST_C45 = 2'b00;
    localparam logic [1:0] OP_C22_RD = 2'b10;
    localparam logic [1:0] OP_C22_WR = 2'b01;
    localparam logic [1:0] OP_C45_ADR = 2'b00;
    localparam logic [1:0] OP_C45_RD = 2'b11;
    localparam logic [1:0] OP_C45_WR = 2'b01;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic bit_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap    = run && (cnt == LAST);
    assign bit_end = wrap && mdc;   // high phase ends: bit time ends

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
    import mdio_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int DEV_W  = 5,
    parameter int DATA_W = 16,
    localparam int ADDR_W = DEV_W + DATA_W,
    localparam int HDR_W  = 4 + PHY_W + DEV_W
) (
    input  frame_kind_e        kind,
    input  logic [PHY_W-1:0]   phy,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [HDR_W-1:0]   hdr,
    output logic [DATA_W-1:0]  word,
    output logic               is_write
);
    logic [1:0]       st;
    logic [1:0]       op;
    logic [DEV_W-1:0] dev;
    logic             ext;

    always_comb begin
        ext = (kind == K_C45_ADR) || (kind == K_C45_RD) || (kind == K_C45_WR);
        unique case (kind)
            K_C22_RD:  op = OP_C22_RD;
            K_C22_WR:  op = OP_C22_WR;
            K_C45_ADR: op = OP_C45_ADR;
            K_C45_RD:  op = OP_C45_RD;
            default:   op = OP_C45_WR;
        endcase
        st       = ext ? ST_C45 : ST_C22;
        dev      = ext ? addr[ADDR_W-1:DATA_W] : addr[DEV_W-1:0];
        hdr      = {st, op, phy, dev};
        word     = (kind == K_C45_ADR) ? addr[DATA_W-1:0] : wdata;
        is_write = (kind != K_C22_RD) && (kind != K_C45_RD);
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC   = 40,
    parameter int PHY_W      = 5,
    parameter int DEV_W      = 5,
    parameter int DATA_W     = 16,
    parameter int PRE_BITS   = 32,
    parameter int FLUSH_BITS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      wr,
    input  logic                      c45,
    input  logic [PHY_W-1:0]          phy_addr,
    input  logic [DEV_W+DATA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic                      busy,
    output logic [DATA_W-1:0]         rdata,
    output logic                      err,
    output logic                      mdc,
    output logic                      mdo,
    output logic                      mdo_oe,
    input  logic                      mdi
);
    localparam int ADDR_W = DEV_W + DATA_W;
    localparam int HDR_W  = 4 + PHY_W + DEV_W;
    localparam int BC_W   = $clog2(PRE_BITS + FLUSH_BITS + DATA_W + HDR_W);

    mdio_state_e          state, state_n;
    frame_kind_e          kind;
    logic [BC_W-1:0]      bit_cnt;
    logic [PHY_W-1:0]     lat_phy;
    logic [ADDR_W-1:0]    lat_addr;
    logic [DATA_W-1:0]    lat_wdata;
    logic                 lat_wr;
    logic [HDR_W-1:0]     hdr_sh;
    logic [DATA_W-1:0]    dat_sh;
    logic [DATA_W-1:0]    rx_sh;
    logic                 bit_end;
    logic                 last;
    logic                 run;
    logic [HDR_W-1:0]     fmt_hdr;
    logic [DATA_W-1:0]    fmt_word;
    logic                 fmt_wr;

    assign run  = (state != S_IDLE);
    assign last = (bit_cnt == '0);

    mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_mdc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mdc     (mdc),
        .bit_end (bit_end)
    );

    mdio_frame_fmt #(.PHY_W(PHY_W), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_fmt (
        .kind     (kind),
        .phy      (lat_phy),
        .addr     (lat_addr),
        .wdata    (lat_wdata),
        .hdr      (fmt_hdr),
        .word     (fmt_word),
        .is_write (fmt_wr)
    );

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:     if (start) state_n = S_PREAMBLE;
            S_PREAMBLE: if (bit_end && last) state_n = S_HEADER;
            S_HEADER:   if (bit_end && last) state_n = fmt_wr ? S_WR_TA : S_RD_TA;
            S_WR_TA:    if (bit_end && last) state_n = S_WR_DATA;
            S_WR_DATA:  if (bit_end && last) state_n = S_TAIL;
            S_RD_TA:    if (bit_end) state_n = mdi ? S_FLUSH : S_RD_DATA;
            S_RD_DATA:  if (bit_end && last) state_n = S_TAIL;
            S_FLUSH:    if (bit_end && last) state_n = S_TAIL;
            S_TAIL:     if (bit_end) state_n = (kind == K_C45_ADR) ? S_PREAMBLE : S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // bit counter, shifters and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind      <= K_C22_RD;
            bit_cnt   <= '0;
            lat_phy   <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            hdr_sh    <= '0;
            dat_sh    <= '0;
            rx_sh     <= '0;
            rdata     <= '0;
            err       <= 1'b0;
        end else if (state == S_IDLE) begin
            if (start) begin
                lat_phy   <= phy_addr;
                lat_addr  <= reg_addr;
                lat_wdata <= wdata;
                lat_wr    <= wr;
                kind      <= c45 ? K_C45_ADR : (wr ? K_C22_WR : K_C22_RD);
                bit_cnt   <= BC_W'(PRE_BITS - 1);
                err       <= 1'b0;
            end
        end else if (bit_end) begin
            if (!last) bit_cnt <= bit_cnt - 1'b1;
            unique case (state)
                S_PREAMBLE: if (last) begin
                    hdr_sh  <= fmt_hdr;
                    bit_cnt <= BC_W'(HDR_W - 1);
                end
                S_HEADER: begin
                    hdr_sh <= hdr_sh << 1;
                    if (last) begin
                        dat_sh  <= fmt_word;
                        bit_cnt <= fmt_wr ? BC_W'(1) : '0;
                    end
                end
                S_WR_TA:   if (last) bit_cnt <= BC_W'(DATA_W - 1);
                S_WR_DATA: dat_sh <= dat_sh << 1;
                S_RD_TA:   bit_cnt <= mdi ? BC_W'(FLUSH_BITS - 1) : BC_W'(DATA_W - 1);
                S_RD_DATA: begin
                    rx_sh <= {rx_sh[DATA_W-2:0], mdi};
                    if (last) rdata <= {rx_sh[DATA_W-2:0], mdi};
                end
                S_FLUSH: if (last) begin
                    rdata <= '1;
                    err   <= 1'b1;
                end
                S_TAIL: if (kind == K_C45_ADR) begin
                    kind    <= lat_wr ? K_C45_WR : K_C45_RD;
                    bit_cnt <= BC_W'(PRE_BITS - 1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state != S_IDLE);
        mdo    = 1'b0;
        mdo_oe = 1'b0;
        unique case (state)
            S_PREAMBLE: begin mdo_oe = 1'b1; mdo = 1'b1;              end
            S_HEADER:   begin mdo_oe = 1'b1; mdo = hdr_sh[HDR_W-1];   end
            S_WR_TA:    begin mdo_oe = 1'b1; mdo = bit_cnt[0];        end
            S_WR_DATA:  begin mdo_oe = 1'b1; mdo = dat_sh[DATA_W-1];  end
            default:    ;
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_CYC = 40,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mdc,
    input logic              mdo,
    input logic              mdo_oe,
    input logic              err,
    input logic [DATA_W-1:0] rdata
);
    logic [15:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_len <= '0;
        else if (mdc) hi_len <= hi_len + 1'b1;
        else          hi_len <= '0;
    end

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdo_oe));

    p_data_low_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdo_oe && !$stable(mdo)) |-> !mdc);

    p_high_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_len == 16'(HALF_CYC)));

    p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_drive_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mdo_oe |-> busy);

    p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !err);

    p_err_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == '1));
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC), .DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .mdc    (mdc),
    .mdo    (mdo),
    .mdo_oe (mdo_oe),
    .err    (err),
    .rdata  (rdata)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int HALF = 40;
    localparam int BITC = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic        c45 = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [20:0] reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, err, mdc, mdo, mdo_oe;
    logic [15:0] rdata;
    logic        mdio_bus;

    logic        phy_oe = 1'b0;
    logic        phy_d = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        phy_mute = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign mdio_bus = mdo_oe ? mdo : (phy_oe ? phy_d : 1'b1);

    mdio_master #(.HALF_CYC(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .c45(c45),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .busy(busy), .rdata(rdata), .err(err),
        .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdio_bus)
    );

    // ---------------- frame decoding responder ----------------
    logic [13:0] fr_hdr [32];
    logic [15:0] fr_dat [32];
    logic [1:0]  fr_ta  [32];
    int          fr_pre [32];
    int          nfr = 0;
    int          ones = 0;
    int          k = 0;
    int          cur_pre = 0;
    bit          in_fr = 0;
    bit          rd_fr = 0;
    logic [13:0] hsh = '0;
    logic [15:0] dsh = '0;
    logic [1:0]  ta = '0;

    task automatic log_frame();
        if (nfr < 32) begin
            fr_hdr[nfr] = hsh;
            fr_dat[nfr] = dsh;
            fr_ta[nfr]  = ta;
            fr_pre[nfr] = cur_pre;
        end
        nfr++;
        in_fr = 0;
        ones  = 0;
    endtask

    always @(posedge mdc) begin
        logic b;
        b = mdio_bus;
        if (!in_fr) begin
            if (mdo_oe && b) ones++;
            else if (mdo_oe && !b && ones >= 32) begin
                in_fr = 1; cur_pre = ones; ones = 0; k = 1;
                hsh = {13'b0, b}; ta = '0; dsh = '0;
            end else ones = 0;
        end else if (k < 14) begin
            hsh = {hsh[12:0], b};
            k++;
            if (k == 14)
                rd_fr = (hsh[13:12] == 2'b01 && hsh[11:10] == 2'b10) ||
                        (hsh[13:12] == 2'b00 && hsh[11:10] == 2'b11);
        end else if (rd_fr) begin
            if (k == 14) begin
                if (phy_mute) log_frame();
                else begin phy_oe = 1'b1; phy_d = 1'b0; end
            end else if (k <= 30) begin
                phy_d = phy_rdata[30-k];
            end else begin
                phy_oe = 1'b0;
                log_frame();
            end
            k++;
        end else begin
            if (k < 16) ta = {ta[0], b};
            else        dsh = {dsh[14:0], b};
            if (k == 31) log_frame();
            k++;
        end
    end

    // ---------------- timing monitors ----------------
    int cyc = 0;
    int rise_cyc = 0;
    int fall_cyc = 0;
    bit have_fall = 0;
    int hi_bad = 0;
    int lo_bad = 0;
    int chg_bad = 0;
    int contention = 0;
    logic prev_mdo = 1'b0;
    logic prev_oe = 1'b0;

    always @(posedge clk) cyc++;
    always @(posedge mdc) begin
        if (have_fall && (cyc - fall_cyc) < HALF) lo_bad++;
        rise_cyc = cyc;
    end
    always @(negedge mdc) begin
        if ((cyc - rise_cyc) != HALF) hi_bad++;
        fall_cyc = cyc;
        have_fall = 1;
    end
    always @(negedge clk) begin
        if (rst_n && mdo_oe && prev_oe && (mdo != prev_mdo) && mdc) chg_bad++;
        if (mdo_oe && phy_oe) contention++;
        prev_mdo = mdo;
        prev_oe  = mdo_oe;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] ehdr(input bit ext, input bit adr, input bit w,
                                         input logic [4:0] p, input logic [4:0] d);
        logic [1:0] s, o;
        s = ext ? 2'b00 : 2'b01;
        if (ext) o = adr ? 2'b00 : (w ? 2'b01 : 2'b11);
        else     o = w ? 2'b01 : 2'b10;
        return {s, o, p, d};
    endfunction

    function automatic int exp_bits(input bit ext, input bit w, input bit m);
        int one;
        one = w ? 65 : (m ? 80 : 64);
        return ext ? 65 + one : one;
    endfunction

    task automatic start_cmd(input bit e, input bit w, input logic [4:0] p,
                             input logic [20:0] a, input logic [15:0] d);
        @(negedge clk);
        c45 = e; wr = w; phy_addr = p; reg_addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int cycles);
        while (busy && cycles < 20000) begin
            cycles++;
            @(negedge clk);
        end
        check(cycles < 20000, "R8 timeout", cycles, 0);
    endtask

    task automatic check_frame(input int idx, input logic [13:0] eh, input bit w,
                               input logic [15:0] ed, input string req);
        check(fr_pre[idx] == 32, "R1 preamble", fr_pre[idx], 32);
        check(fr_hdr[idx] == eh, req, fr_hdr[idx], eh);
        if (w) begin
            check(fr_ta[idx] == 2'b10, "R4 turnaround", fr_ta[idx], 2'b10);
            check(fr_dat[idx] == ed, "R4 data", fr_dat[idx], ed);
        end
    endtask

    typedef struct packed {
        logic        c45;
        logic        wr;
        logic [4:0]  phy;
        logic [20:0] addr;
        logic [15:0] wdata;
        logic [15:0] prd;
        logic        mute;
    } vec_t;

    localparam logic [60:0] VECS [7] = '{
        {1'b0, 1'b1, 5'h03, 21'h000004, 16'hA5C3, 16'h0000, 1'b0},
        {1'b0, 1'b0, 5'h1F, 21'h00001F, 16'h0000, 16'h8001, 1'b0},
        {1'b0, 1'b0, 5'h00, 21'h000000, 16'h0000, 16'h7FFE, 1'b0},
        {1'b0, 1'b0, 5'h05, 21'h000002, 16'h0000, 16'h1234, 1'b1},
        {1'b1, 1'b1, 5'h11, 21'h1E1234, 16'h0F0F, 16'h0000, 1'b0},
        {1'b1, 1'b0, 5'h0A, 21'h01C003, 16'h0000, 16'h5A96, 1'b0},
        {1'b1, 1'b0, 5'h02, 21'h070001, 16'h0000, 16'h0000, 1'b1}
    };

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 190000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        int base;
        int cyc_n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(!busy && !mdc && !mdo_oe, "R12 reset outputs", {busy, mdc, mdo_oe}, 0);
        check(!err && rdata == 16'h0, "R12 reset results", {err, rdata}, 0);

        for (int i = 0; i < 7; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            phy_rdata = v.prd;
            phy_mute  = v.mute;
            base = nfr;
            cyc_n = 0;
            start_cmd(v.c45, v.wr, v.phy, v.addr, v.wdata);
            wait_done(cyc_n);
            repeat (3) @(negedge clk);
            check(cyc_n == exp_bits(v.c45, v.wr, v.mute) * BITC, "R8 busy length",
                  cyc_n, exp_bits(v.c45, v.wr, v.mute) * BITC);
            check(nfr - base == (v.c45 ? 2 : 1), "R7 frame count", nfr - base, v.c45 ? 2 : 1);
            if (v.c45) begin
                check_frame(base, ehdr(1, 1, 0, v.phy, v.addr[20:16]), 1,
                            v.addr[15:0], "R7 address frame header");
                check_frame(base + 1, ehdr(1, 0, v.wr, v.phy, v.addr[20:16]), v.wr,
                            v.wdata, "R2 R7 data frame header");
            end else begin
                check_frame(base, ehdr(0, 0, v.wr, v.phy, v.addr[4:0]), v.wr,
                            v.wdata, "R2 R3 header");
            end
            if (!v.wr) begin
                if (v.mute) begin
                    check(rdata == 16'hFFFF, "R6 flush data", rdata, 16'hFFFF);
                    check(err == 1'b1, "R6 error flag", err, 1);
                end else begin
                    check(rdata == v.prd, "R5 read data", rdata, v.prd);
                    check(err == 1'b0, "R5 no error", err, 0);
                end
            end
        end
        phy_mute = 1'b0;

        // R11: read result holds while idle
        phy_rdata = 16'h3C3C;
        cyc_n = 0;
        start_cmd(0, 0, 5'h09, 21'h00000C, 16'h0);
        wait_done(cyc_n);
        repeat (500) @(negedge clk);
        check(rdata == 16'h3C3C && !err, "R11 read data held", rdata, 16'h3C3C);

        // R10: start while busy ignored
        base = nfr;
        cyc_n = 0;
        start_cmd(0, 1, 5'h06, 21'h000011, 16'hBEEF);
        repeat (200) begin cyc_n++; @(negedge clk); end
        c45 = 1; wr = 0; phy_addr = 5'h1A; reg_addr = 21'h0F00FF; start = 1'b1;
        @(negedge clk); cyc_n++;
        start = 1'b0;
        wait_done(cyc_n);
        repeat (3) @(negedge clk);
        check(nfr - base == 1, "R10 ignored start frame count", nfr - base, 1);
        check_frame(base, ehdr(0, 0, 1, 5'h06, 5'h11), 1, 16'hBEEF, "R10 header kept");
        check(cyc_n == 65 * BITC, "R10 busy length", cyc_n, 65 * BITC);
        check(!busy, "R10 idle after", busy, 0);

        // R11: error held, then cleared by the next accepted command
        phy_mute = 1'b1;
        cyc_n = 0;
        start_cmd(0, 0, 5'h01, 21'h000001, 16'h0);
        wait_done(cyc_n);
        phy_mute = 1'b0;
        repeat (300) @(negedge clk);
        check(err == 1'b1 && rdata == 16'hFFFF, "R11 error held", {err, rdata}, 17'h1FFFF);
        start_cmd(0, 1, 5'h01, 21'h000001, 16'h0055);
        check(busy == 1'b1, "R10 busy after strobe", busy, 1);
        check(err == 1'b0, "R11 error cleared on start", err, 0);
        cyc_n = 0;
        wait_done(cyc_n);

        // R9 / R5 timing and line ownership
        repeat (10) @(negedge clk);
        check(!mdc && !mdo_oe, "R9 idle low", {mdc, mdo_oe}, 0);
        check(hi_bad == 0, "R9 high phase length", hi_bad, 0);
        check(lo_bad == 0, "R9 low phase length", lo_bad, 0);
        check(chg_bad == 0, "R9 data change while high", chg_bad, 0);
        check(contention == 0, "R5 line released while PHY drives", contention, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule